// File: doc/BRIEF.md
# Translation Entry Update Engine

This block owns a small table of 64-bit DMA translation entries and runs the commands that change or read it. Each command names an operation, a table identifier, a bus address, a value field and a page count. A single put writes one entry. A get returns one entry. A fill (stuff) writes one value into a run of consecutive pages. A list put fetches 64-bit entries from memory and writes them into consecutive pages. Every entry written is announced on a notification strobe. The strobe carries the page's I/O virtual address relative to the window base, the masked target address and the access permission.

The table geometry is fixed by parameters: the entry count, the page shift, the window base on the bus and the identifier this table answers to. The engine takes one command at a time. Between acceptance and completion it holds its ready output low. It reports completion with a one-cycle done pulse, which comes with a status bit and, for a get, the returned entry. List entries arrive through a request/acknowledge read port that is 64 bits wide.

The controller steps through five states. IDLE accepts a command (IDLE→CHECK). CHECK validates the command. It goes CHECK→DONE on a rejection, on a finished get or on a zero page count. It goes CHECK→FETCH for a list put and CHECK→WRITE for a put or fill. FETCH holds a list read request until it is acknowledged (FETCH→WRITE). WRITE handles one page. It goes WRITE→DONE on an out-of-range page or after the last page. It goes WRITE→FETCH when the next list entry is needed, and stays in WRITE for the next fill page. DONE pulses done and returns to IDLE.

Top module: `tce_update_engine`

## Requirements
- R1: After reset, cmd_ready is 1, done, ntf_valid and lst_req are 0, and every table entry reads back as zero.
- R2: A command is rejected with status 1, and writes nothing, when any of cmd_id bits 63:32 is set or cmd_id bits 31:0 differ from the configured identifier.
- R3: The bus address is rounded down to a page boundary before use, so any offset within a page selects that page.
- R4: The page index is (bus address − window base) >> page shift. An index at or above the entry count, including an address below the base, gives status 1 and no write.
- R5: A successful get (opcode 1) returns the stored entry on get_data. A rejected get leaves get_data unchanged.
- R6: A fill (opcode 2) whose page count exceeds the entry count is rejected. Otherwise the same value is written to each consecutive page.
- R7: A list put (opcode 3) is rejected without any list read if its count exceeds 512 or if cmd_val bits 11:0 are not zero. Otherwise entry i is read from cmd_val + 8·i and written to the i-th consecutive page. The entry is big-endian: the port carries the byte at address+k on lst_data bits 8k+7:8k, and that byte is entry byte 7−k.
- R8: A fill or list put ends at the first out-of-range page with status 1. The earlier pages keep the values written to them. A list put has already fetched the entry for the failing page.
- R9: Each write pulses ntf_valid for one cycle. ntf_iova is the page address minus the window base. ntf_addr is the entry with its in-page bits cleared. ntf_perm is entry bits 1:0 (0 none, 1 read only, 2 write only, 3 read and write).
- R10: A fill or list put with a page count of zero completes with status 0, writes nothing and reads nothing.
- R11: Opcodes are 0 put, 1 get, 2 fill, 3 list put. cmd_ready is 1 only in IDLE. done is a single-cycle pulse. status is 0 for success and 1 for parameter error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 2 | Operation code |
| cmd_id | input | 64 | Table identifier |
| cmd_ioba | input | 64 | Bus address of the first page |
| cmd_val | input | 64 | Entry value (put, fill) or list address (list put) |
| cmd_npages | input | 32 | Page count (fill, list put) |
| done | output | 1 | Completion pulse |
| status | output | 1 | 0 success, 1 parameter error |
| get_data | output | 64 | Entry returned by the last successful get |
| lst_req | output | 1 | List read request |
| lst_addr | output | 64 | List read byte address |
| lst_ack | input | 1 | List read data valid |
| lst_data | input | 64 | List read data, byte at address+k on lane k |
| ntf_valid | output | 1 | Entry written strobe |
| ntf_iova | output | 64 | Written page address relative to window base |
| ntf_addr | output | 64 | Page-masked target address |
| ntf_perm | output | 2 | Decoded access permission |

## Verification
The bench sweeps a fill from every start page with counts from zero to past the table size. A design that gets the loop bounds wrong either writes one page too many or stops one page short. It also fails to keep the earlier pages after it meets the table end. List puts run from every start page, with counts that include 512, 513 and an unaligned list address. The bench counts the list reads in each case, so a fetch on a rejected command or a missing byte swap shows up. Single puts go to every page with every permission and with in-page offsets. Further puts fall just below the window base and at the entry count, and commands carry both kinds of bad identifier. After each of these, get sweeps catch any unmasked address, wrapped index or stray write.

// File: rtl/tce_pkg.sv
`timescale 1ns/1ps
package tce_pkg;
    typedef enum logic [1:0] {
        OP_PUT   = 2'd0,
        OP_GET   = 2'd1,
        OP_STUFF = 2'd2,
        OP_LIST  = 2'd3
    } tce_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_WRITE,
        ST_DONE
    } tce_state_e;

    localparam logic STAT_OK    = 1'b0;
    localparam logic STAT_PARAM = 1'b1;
    localparam int   LIST_MAX   = 512;
    localparam int   LIST_ALIGN = 12;
    localparam int   ID_W       = 32;
endpackage

// File: rtl/tce_entry_ram.sv
`timescale 1ns/1ps
module tce_entry_ram #(
    parameter int DEPTH = 16,
    parameter int DW    = 64,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tce_page_index.sv
`timescale 1ns/1ps
module tce_page_index #(
    parameter int              AW         = 64,
    parameter int              PAGE_SHIFT = 12,
    parameter logic [AW-1:0]   BUS_OFFSET = '0,
    parameter int              DEPTH      = 16,
    localparam int             IW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0] page_addr,
    output logic [IW-1:0] index,
    output logic          in_range,
    output logic [AW-1:0] rel_iova
);
    localparam logic [AW-1:0] LOW_MASK = (AW'(1) << PAGE_SHIFT) - AW'(1);

    logic [AW-1:0] rel;
    logic [AW-1:0] full_idx;

    always_comb begin
        rel      = page_addr - BUS_OFFSET;
        full_idx = rel >> PAGE_SHIFT;
        in_range = full_idx < AW'(DEPTH);
        index    = full_idx[IW-1:0];
        rel_iova = rel & ~LOW_MASK;
    end
endmodule

// File: rtl/tce_update_engine.sv
`timescale 1ns/1ps
module tce_update_engine
    import tce_pkg::*;
#(
    parameter int            AW         = 64,
    parameter int            DW         = 64,
    parameter int            CW         = 32,
    parameter int            ENTRIES    = 16,
    parameter int            PAGE_SHIFT = 12,
    parameter logic [63:0]   BUS_OFFSET = 64'h0,
    parameter logic [31:0]   TABLE_ID   = 32'h1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_id,
    input  logic [AW-1:0] cmd_ioba,
    input  logic [DW-1:0] cmd_val,
    input  logic [CW-1:0] cmd_npages,
    output logic          done,
    output logic          status,
    output logic [DW-1:0] get_data,
    output logic          lst_req,
    output logic [AW-1:0] lst_addr,
    input  logic          lst_ack,
    input  logic [DW-1:0] lst_data,
    output logic          ntf_valid,
    output logic [AW-1:0] ntf_iova,
    output logic [AW-1:0] ntf_addr,
    output logic [1:0]    ntf_perm
);
    localparam int            IW         = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [AW-1:0] PAGE_BYTES = AW'(1) << PAGE_SHIFT;
    localparam logic [AW-1:0] PG_MASK    = ~(PAGE_BYTES - AW'(1));
    localparam logic [DW-1:0] DPG_MASK   = DW'(PG_MASK);
    localparam int            NBYTES     = DW / 8;

    tce_state_e    state, state_nx;
    tce_op_e       op_q;
    logic [AW-1:0] id_q, ioba_q, lptr_q;
    logic [DW-1:0] val_q;
    logic [CW-1:0] remain_q;

    logic [IW-1:0] idx;
    logic          in_range;
    logic [AW-1:0] rel_iova;
    logic [DW-1:0] ram_rdata;
    logic          ram_we;
    logic          id_bad, cnt_bad, check_err;
    logic [DW-1:0] lst_swapped;

    tce_page_index #(
        .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .BUS_OFFSET(AW'(BUS_OFFSET)), .DEPTH(ENTRIES)
    ) u_index (
        .page_addr(ioba_q),
        .index    (idx),
        .in_range (in_range),
        .rel_iova (rel_iova)
    );

    tce_entry_ram #(.DEPTH(ENTRIES), .DW(DW)) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .waddr(idx),
        .wdata(val_q),
        .raddr(idx),
        .rdata(ram_rdata)
    );

    // big-endian list entry: lane k carries entry byte NBYTES-1-k
    always_comb begin
        for (int k = 0; k < NBYTES; k++)
            lst_swapped[8*(NBYTES-1-k) +: 8] = lst_data[8*k +: 8];
    end

    always_comb begin
        id_bad    = (id_q[AW-1:ID_W] != '0) || (id_q[ID_W-1:0] != TABLE_ID);
        cnt_bad   = ((op_q == OP_STUFF) && (remain_q > CW'(ENTRIES))) ||
                    ((op_q == OP_LIST) && ((remain_q > CW'(LIST_MAX)) ||
                                           (lptr_q[LIST_ALIGN-1:0] != '0)));
        check_err = id_bad || cnt_bad || ((op_q == OP_GET) && !in_range);
        ram_we    = (state == ST_WRITE) && in_range;
        cmd_ready = (state == ST_IDLE);
        done      = (state == ST_DONE);
        lst_req   = (state == ST_FETCH);
        lst_addr  = lptr_q;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (check_err || op_q == OP_GET || remain_q == '0) state_nx = ST_DONE;
                else if (op_q == OP_LIST)                           state_nx = ST_FETCH;
                else                                                state_nx = ST_WRITE;
            end
            ST_FETCH: if (lst_ack) state_nx = ST_WRITE;
            ST_WRITE: begin
                if (!in_range || remain_q == CW'(1)) state_nx = ST_DONE;
                else if (op_q == OP_LIST)            state_nx = ST_FETCH;
                else                                 state_nx = ST_WRITE;
            end
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and command datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_PUT;
            id_q     <= '0;
            ioba_q   <= '0;
            val_q    <= '0;
            lptr_q   <= '0;
            remain_q <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    op_q     <= tce_op_e'(cmd_op);
                    id_q     <= cmd_id;
                    ioba_q   <= cmd_ioba & PG_MASK;
                    val_q    <= cmd_val;
                    lptr_q   <= AW'(cmd_val);
                    remain_q <= (tce_op_e'(cmd_op) == OP_STUFF || tce_op_e'(cmd_op) == OP_LIST)
                                ? cmd_npages : CW'(1);
                end
                ST_FETCH: if (lst_ack) begin
                    val_q  <= lst_swapped;
                    lptr_q <= lptr_q + AW'(NBYTES);
                end
                ST_WRITE: if (in_range) begin
                    ioba_q   <= ioba_q + PAGE_BYTES;
                    remain_q <= remain_q - CW'(1);
                end
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status    <= STAT_OK;
            get_data  <= '0;
            ntf_valid <= 1'b0;
            ntf_iova  <= '0;
            ntf_addr  <= '0;
            ntf_perm  <= 2'b00;
        end else begin
            ntf_valid <= 1'b0;
            unique case (state)
                ST_CHECK: begin
                    status <= check_err ? STAT_PARAM : STAT_OK;
                    if (!check_err && op_q == OP_GET) get_data <= ram_rdata;
                end
                ST_WRITE: begin
                    if (!in_range) begin
                        status <= STAT_PARAM;
                    end else begin
                        ntf_valid <= 1'b1;
                        ntf_iova  <= rel_iova;
                        ntf_addr  <= AW'(val_q & DPG_MASK);
                        ntf_perm  <= val_q[1:0];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tce_update_engine_sva.sv
`timescale 1ns/1ps
module tce_update_engine_sva #(
    parameter int AW         = 64,
    parameter int ENTRIES    = 16,
    parameter int PAGE_SHIFT = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          done,
    input logic          lst_req,
    input logic          lst_ack,
    input logic [AW-1:0] lst_addr,
    input logic          ntf_valid,
    input logic [AW-1:0] ntf_iova,
    input logic [AW-1:0] ntf_addr
);
    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !lst_req);

    p_list_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lst_req |-> lst_addr[2:0] == 3'b000);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lst_req && !lst_ack |=> lst_req && $stable(lst_addr));

    p_ntf_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> (ntf_iova[PAGE_SHIFT-1:0] == '0) && (ntf_addr[PAGE_SHIFT-1:0] == '0));

    p_ntf_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> (ntf_iova >> PAGE_SHIFT) < AW'(ENTRIES));
endmodule

bind tce_update_engine tce_update_engine_sva #(
    .AW(AW), .ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT)
) u_sva (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .done(done), .lst_req(lst_req), .lst_ack(lst_ack), .lst_addr(lst_addr),
    .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_addr(ntf_addr)
);

// File: tb/tce_update_engine_bench.sv
`timescale 1ns/1ps
module tce_update_engine_bench;
    localparam int          ENT   = 8;
    localparam int          SH    = 12;
    localparam logic [63:0] OFF   = 64'h0000_0000_0004_0000;
    localparam logic [31:0] TID   = 32'h0000_002A;
    localparam logic [63:0] PG    = 64'h1 << SH;
    localparam logic [63:0] MASK  = ~(PG - 64'h1);
    localparam logic [63:0] LBASE = 64'h0000_0000_0008_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [63:0] cmd_id = '0, cmd_ioba = '0, cmd_val = '0;
    logic [31:0] cmd_npages = '0;
    logic        done, status;
    logic [63:0] get_data;
    logic        lst_req;
    logic [63:0] lst_addr;
    logic        lst_ack = 1'b0;
    logic [63:0] lst_data = '0;
    logic        ntf_valid;
    logic [63:0] ntf_iova, ntf_addr;
    logic [1:0]  ntf_perm;

    tce_update_engine #(
        .ENTRIES(ENT), .PAGE_SHIFT(SH), .BUS_OFFSET(OFF), .TABLE_ID(TID)
    ) u_tce_update_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_ioba(cmd_ioba), .cmd_val(cmd_val),
        .cmd_npages(cmd_npages), .done(done), .status(status), .get_data(get_data),
        .lst_req(lst_req), .lst_addr(lst_addr), .lst_ack(lst_ack), .lst_data(lst_data),
        .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_addr(ntf_addr), .ntf_perm(ntf_perm)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [63:0] mtab [ENT];
    logic [63:0] last_get = '0;
    logic [63:0] got_iova [32];
    logic [63:0] got_addr [32];
    logic [1:0]  got_perm [32];
    int          got_n = 0;
    int          rd_n  = 0;

    function automatic logic [63:0] lmem(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A00_0F00, 16'hC0DE, a[18:3]};
    endfunction

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // list memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (lst_req && !lst_ack) begin
                lst_ack  = 1'b1;
                lst_data = bswap(lmem(lst_addr));
                rd_n++;
            end else begin
                lst_ack = 1'b0;
            end
        end
    end

    // notification monitor
    initial begin
        forever begin
            @(negedge clk);
            if (ntf_valid && got_n < 32) begin
                got_iova[got_n] = ntf_iova;
                got_addr[got_n] = ntf_addr;
                got_perm[got_n] = ntf_perm;
                got_n++;
            end
        end
    end

    task automatic run_cmd(input logic [1:0] op, input logic [63:0] id, input logic [63:0] ioba,
                           input logic [63:0] val, input logic [31:0] np, input string tag);
        logic [63:0] eiova [32];
        logic [63:0] eaddr [32];
        logic [1:0]  eperm [32];
        int          en = 0, erd = 0, cyc = 0;
        logic        est = 1'b0, rej;
        logic [63:0] base, a, v, ix, egd;
        longint      n;
        rej  = (id[63:32] != 0) || (id[31:0] != TID) ||
               (op == 2'd2 && np > ENT) ||
               (op == 2'd3 && (np > 512 || val[11:0] != 0));
        base = ioba & MASK;
        egd  = last_get;
        if (op == 2'd1) begin
            ix = (base - OFF) >> SH;
            if (rej || ix >= ENT) est = 1'b1;
            else egd = mtab[ix[2:0]];
        end else if (rej) begin
            est = 1'b1;
        end else begin
            n = (op == 2'd0) ? 1 : longint'(np);
            for (longint i = 0; i < n; i++) begin
                a = base + 64'(i) * PG;
                v = (op == 2'd3) ? lmem(val + 64'(i) * 8) : val;
                if (op == 2'd3) erd++;
                ix = (a - OFF) >> SH;
                if (ix >= ENT) begin est = 1'b1; break; end
                eiova[en] = ix << SH;
                eaddr[en] = v & MASK;
                eperm[en] = v[1:0];
                en++;
                mtab[ix[2:0]] = v;
            end
        end
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R11", "ready before command", 64'(cmd_ready), 64'h1);
        got_n = 0;
        rd_n  = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_ioba = ioba;
        cmd_val = val; cmd_npages = np;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready === 1'b0, "R11", "ready low while busy", 64'(cmd_ready), 64'h0);
        while (done !== 1'b1 && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        chk(status === est, tag, "status", 64'(status), 64'(est));
        if (op == 2'd1) begin
            chk(get_data === egd, "R5", "get data", get_data, egd);
            last_get = egd;
        end
        @(negedge clk);
        chk(done === 1'b0 && cmd_ready === 1'b1, "R11", "done single pulse", 64'(done), 64'h0);
        chk(got_n == en, tag, "notification count", 64'(got_n), 64'(en));
        for (int k = 0; k < en && k < got_n; k++) begin
            chk(got_iova[k] === eiova[k], "R9", "ntf iova", got_iova[k], eiova[k]);
            chk(got_addr[k] === eaddr[k], "R9", "ntf addr", got_addr[k], eaddr[k]);
            chk(got_perm[k] === eperm[k], "R9", "ntf perm", 64'(got_perm[k]), 64'(eperm[k]));
        end
        chk(rd_n == erd, (op == 2'd3) ? "R7" : tag, "list reads", 64'(rd_n), 64'(erd));
    endtask

    task automatic get_sweep(input string tag);
        for (int i = 0; i < ENT; i++)
            run_cmd(2'd1, 64'(TID), OFF + 64'(i) * PG + 64'h8, 64'h0, 32'd0, tag);
    endtask

    localparam logic [63:0] GID = 64'(TID);

    initial begin
        for (int i = 0; i < ENT; i++) mtab[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cmd_ready === 1'b1, "R1", "ready after reset", 64'(cmd_ready), 64'h1);
        chk(done === 1'b0 && ntf_valid === 1'b0 && lst_req === 1'b0, "R1",
            "idle outputs after reset", {61'h0, done, ntf_valid, lst_req}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        get_sweep("R1");

        // R3 / R9: single puts to every page, every permission, in-page offsets
        for (int i = 0; i < ENT; i++)
            for (int p = 0; p < 4; p++) begin
                run_cmd(2'd0, GID, OFF + 64'(i) * PG + 64'((i * 37 + p * 511) & 12'hFFF),
                        64'hDEAD_0000_0000_0120 ^ (64'(i) << 20) ^ 64'(p) ^ (64'(p) << 40),
                        32'd7, "R3");
                run_cmd(2'd1, GID, OFF + 64'(i) * PG + 64'hFFF, 64'h0, 32'd0, "R5");
            end

        // R4: out-of-range puts
        run_cmd(2'd0, GID, OFF - PG, 64'h1111_0003, 32'd1, "R4");
        run_cmd(2'd0, GID, OFF - 64'h1, 64'h1111_0003, 32'd1, "R4");
        run_cmd(2'd0, GID, OFF + 64'(ENT) * PG, 64'h2222_0001, 32'd1, "R4");
        run_cmd(2'd0, GID, 64'hFFFF_FFFF_FFFF_F000, 64'h2222_0001, 32'd1, "R4");
        get_sweep("R4");

        // R5: get out of range leaves get_data unchanged
        run_cmd(2'd1, GID, OFF + 64'(ENT) * PG, 64'h0, 32'd0, "R5");
        run_cmd(2'd1, GID, OFF - PG, 64'h0, 32'd0, "R5");

        // R2: bad identifiers on every opcode
        for (int o = 0; o < 4; o++) begin
            run_cmd(2'(o), {32'h1, TID}, OFF, LBASE, 32'd2, "R2");
            run_cmd(2'(o), 64'(TID + 32'd1), OFF, LBASE, 32'd2, "R2");
            run_cmd(2'(o), {32'h8000_0000, TID}, OFF + PG, LBASE, 32'd1, "R2");
        end
        get_sweep("R2");

        // R6 / R8 / R10: fill sweep over start page and count
        for (int s = 0; s < ENT; s++)
            for (int c = 0; c <= ENT + 1; c++)
                run_cmd(2'd2, GID, OFF + 64'(s) * PG + 64'h40,
                        64'h0ABC_0000_0000_5000 ^ (64'(s) << 32) ^ (64'(c) << 16) ^ 64'(c & 3),
                        32'(c), (c == 0) ? "R10" : (c > ENT) ? "R6" : (s + c > ENT) ? "R8" : "R6");
        get_sweep("R6");

        // R7 / R8 / R10: list puts
        for (int s = 0; s < ENT; s++) begin
            run_cmd(2'd3, GID, OFF + 64'(s) * PG, LBASE + 64'(s) * 64'h1000, 32'd0, "R10");
            run_cmd(2'd3, GID, OFF + 64'(s) * PG, LBASE + 64'(s) * 64'h1000, 32'd1, "R7");
            run_cmd(2'd3, GID, OFF + 64'(s) * PG, LBASE + 64'(s) * 64'h3000, 32'd3, "R7");
            run_cmd(2'd3, GID, OFF + 64'(s) * PG, LBASE, 32'd512, "R8");
            run_cmd(2'd3, GID, OFF + 64'(s) * PG, LBASE, 32'd513, "R7");
        end
        run_cmd(2'd3, GID, OFF, LBASE + 64'h8, 32'd2, "R7");
        run_cmd(2'd3, GID, OFF, LBASE + 64'h800, 32'd2, "R7");
        run_cmd(2'd3, GID, OFF - PG, LBASE, 32'd2, "R8");
        get_sweep("R7");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule